// File: doc/BRIEF.md
# Gated Frequency Meter with Decimal Readout

This block measures the frequency of a waveform that arrives as a stream of 8-bit samples, one per system clock. Each sample is compared against midscale, which turns it into a one-bit square wave. The block then counts the rising edges of that wave over a fixed gate of system clock cycles. With the default 100 MHz clock the gate lasts one second, so the count is the frequency in hertz.

When a gate closes with a nonzero count, the count is latched as the binary reading. A serial shift-and-add-3 converter then turns it into eight packed decimal digits. A one-cycle strobe marks each new decimal result. A gate that sees no edges leaves the previous reading in place. The edge count stops at a ceiling, so the eight-digit display cannot wrap.

Top module: `freq_gate_meter`

## Requirements
- R1: A sample is treated as high when its unsigned value is 128 or more, and as low at 127 or below. The squared level is registered on the system clock.
- R2: Each gate spans exactly GATE_CYCLES consecutive clocks. The reading of a gate equals the number of low-to-high transitions of the squared wave that fall inside it. The count starts from zero in every gate.
- R3: When a gate ends with a count of zero, `freq_hz` and `bcd` keep their previous values and no strobe is produced. `freq_hz` never changes to zero while the block is out of clear.
- R4: The edge count stops at SAT_LIMIT (default 99,999,999). A gate with more transitions reports exactly SAT_LIMIT.
- R5: `bcd` holds the reading as eight decimal digits. Digit k (weight 10^k) sits in bits [4k+3:4k], with the least significant digit in bits [3:0]. Each digit is 0 to 9.
- R6: `bcd_valid` is high for a single cycle when a conversion finishes. `bcd` changes only in that cycle, and the conversion takes 32 clocks after the reading is latched.
- R7: While `rst_n` is low, `freq_hz`, `bcd` and `bcd_valid` are zero. After `rst_n` is released, a new gate starts, so the first result appears within one gate plus the conversion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the gate |
| rst_n | input | 1 | Active-low asynchronous clear |
| sample | input | 8 | Unsigned waveform sample |
| freq_hz | output | 32 | Latched binary edge count of the last nonzero gate |
| bcd | output | 32 | Eight packed decimal digits of the reading |
| bcd_valid | output | 1 | One-cycle strobe when `bcd` is updated |

## Verification
The squared wave is driven at many periods, from two clocks up to one full gate. Because every period divides the gate length, every gate holds a known whole number of edges whatever its phase. This separates correct gate length and edge counting from off-by-one counting, and it checks decimal digits in several positions.

The fastest period exceeds the ceiling and exercises saturation. Waveforms that sit at 128 and 127 check the threshold from both sides. Waveforms that stay entirely above or entirely below midscale produce zero-edge gates, which must leave the reading untouched. A clear in the middle of a run shows that outputs are zeroed and that the gate restarts.

// File: rtl/freq_gate_meter.sv
module freq_gate_meter #(
  parameter int          SAMPLE_W    = 8,
  parameter int          CNT_W       = 32,
  parameter int          DIGITS      = 8,
  parameter int unsigned GATE_CYCLES = 100_000_000,
  parameter int unsigned SAT_LIMIT   = 99_999_999
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SAMPLE_W-1:0]   sample,
  output logic [CNT_W-1:0]      freq_hz,
  output logic [4*DIGITS-1:0]   bcd,
  output logic                  bcd_valid
);
  // GATE_CYCLES must exceed CNT_W + 2 so a conversion ends before the next capture.
  localparam int BCD_W  = 4 * DIGITS;
  localparam int GATE_W = $clog2(GATE_CYCLES);
  localparam int SH_W   = $clog2(CNT_W);
  localparam logic [SAMPLE_W-1:0] MIDSCALE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]    CEILING  = CNT_W'(SAT_LIMIT);
  localparam logic [GATE_W-1:0]   GATE_END = GATE_W'(GATE_CYCLES - 1);

  logic              sq_q, sq_prev;
  logic [GATE_W-1:0] gate_cnt;
  logic [CNT_W-1:0]  edges, edges_inc, shreg;
  logic [BCD_W-1:0]  acc, adj;
  logic [SH_W-1:0]   shifts;
  logic              busy;

  wire rise     = sq_q & ~sq_prev;
  wire gate_end = (gate_cnt == GATE_END);

  assign edges_inc = (rise && edges < CEILING) ? edges + 1'b1 : edges;

  always_comb begin
    for (int k = 0; k < DIGITS; k++)
      adj[4*k +: 4] = (acc[4*k +: 4] >= 4'd5) ? acc[4*k +: 4] + 4'd3 : acc[4*k +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q     <= 1'b0;
      sq_prev  <= 1'b0;
      gate_cnt <= '0;
      edges    <= '0;
    end else begin
      sq_q     <= (sample >= MIDSCALE);
      sq_prev  <= sq_q;
      gate_cnt <= gate_end ? '0 : gate_cnt + 1'b1;
      edges    <= gate_end ? '0 : edges_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_hz   <= '0;
      shreg     <= '0;
      acc       <= '0;
      shifts    <= '0;
      busy      <= 1'b0;
      bcd       <= '0;
      bcd_valid <= 1'b0;
    end else begin
      bcd_valid <= 1'b0;
      if (gate_end && edges_inc != '0) begin
        freq_hz <= edges_inc;
        shreg   <= edges_inc;
        acc     <= '0;
        shifts  <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        acc    <= {adj[BCD_W-2:0], shreg[CNT_W-1]};
        shreg  <= shreg << 1;
        shifts <= shifts + 1'b1;
        if (shifts == SH_W'(CNT_W - 1)) begin
          busy      <= 1'b0;
          bcd       <= {adj[BCD_W-2:0], shreg[CNT_W-1]};
          bcd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_gate_meter_chk.sv
module freq_gate_meter_chk #(
  parameter int          CNT_W     = 32,
  parameter int          DIGITS    = 8,
  parameter int unsigned SAT_LIMIT = 99_999_999
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    freq_hz,
  input logic [4*DIGITS-1:0] bcd,
  input logic                bcd_valid
);
  localparam logic [CNT_W-1:0] CEILING = CNT_W'(SAT_LIMIT);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_valid |=> !bcd_valid);

  assert_bcd_only_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bcd) |-> bcd_valid);

  assert_no_zero_reading_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_hz) |-> freq_hz != '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    freq_hz <= CEILING);

  assert_clear_outputs_R7: assert property (@(posedge clk)
    !rst_n |=> (freq_hz == '0 && bcd == '0 && !bcd_valid));

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_valid |-> bcd[4*k +: 4] <= 4'd9);
  end
endmodule

bind freq_gate_meter freq_gate_meter_chk #(
  .CNT_W(CNT_W), .DIGITS(DIGITS), .SAT_LIMIT(SAT_LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .freq_hz(freq_hz), .bcd(bcd), .bcd_valid(bcd_valid)
);

// File: tb/freq_gate_meter_tb_top.sv
module freq_gate_meter_tb_top;
  localparam int GATE = 2400;
  localparam int SAT  = 999;
  localparam int NVEC = 9;
  // {period, expected reading}
  localparam int VEC [NVEC][2] = '{
    '{4, 600}, '{3, 800}, '{5, 480}, '{8, 300}, '{16, 150},
    '{25, 96}, '{6, 400}, '{2400, 1}, '{2, 999}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sample = 8'd0;
  logic [31:0] freq_hz, bcd;
  logic        bcd_valid;

  int checks = 0, errors = 0;
  int per = 4, phase = 0, strobes = 0;
  logic [7:0] hi = 8'd200, lo = 8'd20;

  always #2 clk = ~clk;

  freq_gate_meter #(.GATE_CYCLES(GATE), .SAT_LIMIT(SAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .freq_hz(freq_hz), .bcd(bcd), .bcd_valid(bcd_valid));

  always @(negedge clk) begin
    phase  = (phase >= per - 1) ? 0 : phase + 1;
    sample = (phase < per / 2 || phase == 0) ? hi : lo;
    if (bcd_valid) strobes++;
  end

  function automatic logic [31:0] to_dec(int v);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d (0x%h) expected %0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!bcd_valid);
  endtask

  task automatic measure(string req, int p, logic [7:0] h, logic [7:0] l, int exp);
    per = p; hi = h; lo = l;
    wait_strobe();
    wait_strobe();
    check(req, freq_hz, exp);
    check("R5", bcd, to_dec(exp));
  endtask

  task automatic expect_hold(string req, logic [7:0] h, logic [7:0] l);
    int s0;
    logic [31:0] f0, b0;
    hi = h; lo = l;
    repeat (GATE + 40) @(negedge clk);
    s0 = strobes; f0 = freq_hz; b0 = bcd;
    repeat (2 * GATE + 40) @(negedge clk);
    check(req, strobes - s0, 0);
    check(req, freq_hz, f0);
    check(req, bcd, b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", freq_hz, 0);
    check("R7", bcd, 0);
    check("R7", 32'(bcd_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      measure(VEC[i][0] == 2 ? "R4" : "R2", VEC[i][0], 8'd200, 8'd20, VEC[i][1]);

    // R1: threshold boundary, 128 high and 127 low
    measure("R1", 10, 8'd128, 8'd127, 240);
    // R1 R3: both levels below midscale give no edges, reading holds
    per = 4;
    expect_hold("R1", 8'd127, 8'd0);
    // R3: both levels at or above midscale give no edges
    expect_hold("R3", 8'd255, 8'd128);

    // R6: strobe is one cycle wide
    measure("R2", 12, 8'd200, 8'd20, 200);
    per = 12;
    wait_strobe();
    @(negedge clk);
    check("R6", 32'(bcd_valid), 0);

    // R7: mid-run clear, then gate restarts
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", freq_hz, 0);
    check("R7", bcd, 0);
    per = 5;
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!bcd_valid && n < GATE + 60);
      check("R7", 32'(bcd_valid), 1);
    end
    wait_strobe();
    check("R7", freq_hz, 480);
    check("R5", bcd, to_dec(480));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule